// File: doc/BRIEF.md
# Eight-Source Two-Level Interrupt Controller

This block collects interrupt requests for an 8-bit microcontroller core and decides which one the core should service next. It watches four active-low external pins and four request lines from on-chip peripherals (two timers, a serial port and a third timer). It keeps the pending flags for the external pins, applies a per-source enable, a global enable and a per-source priority bit, and presents the core with a request and the fixed entry address of the winning source.

The core answers with a one-cycle acknowledge when it enters the handler and a one-cycle return pulse when the handler ends. The block tracks which priority levels are in service, so a high-priority source can interrupt a low-priority handler but never the reverse. Software reaches all control state through a byte-wide register port and through a single-bit write port. The single-bit port addresses each bit of a register as the register's byte address plus the bit number.

Top module: `irq_arbiter8`

## Requirements
- R1: After a synchronous reset, all four control registers read 00h and no request is presented (`irq_o` low).
- R2: Register map. At A8h, bit 7 is the global enable, bits 5..0 enable sources 0..5 and bit 6 reads 0. At B8h, bits 5..0 are the priorities of sources 0..5 (1 = high) and bits 7..6 read 0. At 88h, bit 0 is the mode of pin 0 (1 = falling edge, 0 = low level), bit 1 is the flag of pin 0, bit 2 is the mode of pin 1 and bit 3 is the flag of pin 1. At C0h, from bit 7 down, are priority 3, enable 3, flag 3, mode 3, priority 2, enable 2, flag 2 and mode 2 of pins 2 and 3.
- R3: A single-bit write to bit address B changes only bit B[2:0] of the register at byte address {B[7:3],000}.
- R4: Sources are numbered 0..7 as pin 0, timer 0, pin 1, timer 1, serial, timer 2, pin 2 and pin 3. The vector presented for source i is 8*i+3 (03h, 0Bh, ... 3Bh).
- R5: A source competes only when its request, its enable and the global enable are all set.
- R6: Among competing sources of the same level, the lowest-numbered source wins.
- R7: Any competing high-priority source wins over every low-priority source, whatever the source numbers.
- R8: While a low-level handler is in service, only high-priority sources are presented. While a high-level handler is in service, nothing is presented.
- R9: A return pulse ends the most recently entered level, high before low. A high-level return leaves a pre-empted low level still in service.
- R10: In edge mode, a falling edge on a pin sets its flag three clock edges after the pin changes. The flag stays set after the pin rises and is cleared when that source is acknowledged.
- R11: In level mode, the flag follows the inverted synchronized pin with the same latency. Software writes to the flag and acknowledges leave it unchanged.
- R12: In edge mode, a software write to a flag takes precedence over a falling edge detected in the same cycle.
- R13: The four peripheral request lines are level inputs that take part in arbitration in the same cycle as they are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_n_i | input | 4 | External interrupt pins 0..3, active low, asynchronous |
| periph_i | input | 4 | Peripheral requests: timer 0, timer 1, serial, timer 2 |
| sfr_we_i | input | 1 | Byte register write strobe |
| sfr_addr_i | input | 8 | Byte register address for write and read |
| sfr_wdata_i | input | 8 | Byte write data |
| sfr_rdata_o | output | 8 | Read data for `sfr_addr_i` (combinational) |
| bit_we_i | input | 1 | Single-bit write strobe |
| bit_addr_i | input | 8 | Bit address (byte address plus bit number) |
| bit_val_i | input | 1 | Value written by the single-bit port |
| irq_o | output | 1 | A source is presented to the core |
| irq_vec_o | output | 16 | Entry address of the presented source |
| ack_i | input | 1 | Core enters the handler of the presented source |
| reti_i | input | 1 | Core returns from the current handler |

## Verification
The hardest state to reach is a two-deep nesting, with a low-level handler pre-empted by a high one and a further request pending at each level. The bench builds it one step at a time with the peripheral lines and a level-mode pin, checking after every acknowledge and return which source is presented. The other hard case is a software write that must land in exactly the cycle in which the edge detector fires. The bench counts the synchronizer edges from the pin change and places the write strobe over the third edge. Priority and enable selection are swept over all 256 request patterns under several priority masks and over all 256 enable masks.

// File: rtl/irq8_pkg.sv
package irq8_pkg;

    localparam int unsigned NSRC  = 8;
    localparam int unsigned NEXT  = 4;
    localparam int unsigned SRC_W = $clog2(NSRC);

    localparam logic [7:0] ADDR_EN  = 8'hA8;
    localparam logic [7:0] ADDR_PR  = 8'hB8;
    localparam logic [7:0] ADDR_EXT = 8'h88;
    localparam logic [7:0] ADDR_XC  = 8'hC0;

    localparam logic [15:0] VEC_BASE = 16'h0003;
    localparam int unsigned VEC_STEP = 8;

    typedef enum logic [SRC_W-1:0] {
        SRC_PIN0, SRC_TMR0, SRC_PIN1, SRC_TMR1,
        SRC_SER,  SRC_TMR2, SRC_PIN2, SRC_PIN3
    } src_e;

    typedef struct packed {
        logic we;
        logic val;
    } bitwr_t;

    typedef struct packed {
        logic             valid;
        logic             hi;
        logic [SRC_W-1:0] idx;
    } pick_t;

    function automatic bitwr_t bit_wr(input logic byte_hit, input logic bit_hit,
                                      input logic [2:0] bidx, input logic bval,
                                      input logic wbit, input logic [2:0] pos);
        bitwr_t r;
        logic   sel;
        sel   = bit_hit && (bidx == pos);
        r.we  = byte_hit | sel;
        r.val = sel ? bval : wbit;
        return r;
    endfunction

    function automatic logic [SRC_W-1:0] first_set(input logic [NSRC-1:0] m);
        logic [SRC_W-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (m[i]) r = SRC_W'(i);
        end
        return r;
    endfunction

    function automatic logic [15:0] vec_of(input logic [SRC_W-1:0] idx);
        return VEC_BASE + 16'(idx) * 16'(VEC_STEP);
    endfunction

    function automatic logic [SRC_W-1:0] pin_src(input int c);
        case (c)
            0:       return SRC_PIN0;
            1:       return SRC_PIN1;
            2:       return SRC_PIN2;
            default: return SRC_PIN3;
        endcase
    endfunction

endpackage

// File: rtl/irq8_ext_chan.sv
module irq8_ext_chan #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n_i,
    input  logic edge_mode_i,
    input  logic sw_we_i,
    input  logic sw_val_i,
    input  logic ack_clr_i,
    output logic flag_o
);

    logic [SYNC_STAGES-1:0] sh_q;
    logic                   prev_q;
    logic                   flag_q;
    logic                   cur;
    logic                   fall;

    assign cur  = sh_q[SYNC_STAGES-1];
    assign fall = prev_q & ~cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '1;
            prev_q <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[SYNC_STAGES-2:0], pin_n_i};
            prev_q <= cur;
            if (!edge_mode_i)   flag_q <= ~cur;
            else if (sw_we_i)   flag_q <= sw_val_i;
            else if (fall)      flag_q <= 1'b1;
            else if (ack_clr_i) flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

    // R10
    edge_set_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode_i && !sw_we_i && fall) |=> flag_o)
        else $error("edge not latched");

    // R10
    ack_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode_i && !sw_we_i && !fall && ack_clr_i) |=> !flag_o)
        else $error("acknowledge did not clear edge flag");

    // R12
    sw_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode_i && sw_we_i) |=> (flag_o == $past(sw_val_i)))
        else $error("software write lost");

    // R11
    level_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!edge_mode_i && !ack_clr_i) |=> (flag_o == !$past(sh_q[SYNC_STAGES-1])))
        else $error("level flag does not follow pin");

endmodule

// File: rtl/irq8_pick.sv
module irq8_pick
    import irq8_pkg::*;
(
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] prio_i,
    input  logic            in_hi_i,
    input  logic            in_lo_i,
    output pick_t           pick_o
);

    logic [NSRC-1:0] hi_req;
    logic [NSRC-1:0] lo_req;

    assign hi_req = req_i & prio_i;
    assign lo_req = req_i & ~prio_i;

    always_comb begin
        pick_o = '0;
        if (!in_hi_i) begin
            if (|hi_req) begin
                pick_o.valid = 1'b1;
                pick_o.hi    = 1'b1;
                pick_o.idx   = first_set(hi_req);
            end else if (!in_lo_i && |lo_req) begin
                pick_o.valid = 1'b1;
                pick_o.hi    = 1'b0;
                pick_o.idx   = first_set(lo_req);
            end
        end
    end

endmodule

// File: rtl/irq8_nest.sv
module irq8_nest (
    input  logic clk,
    input  logic rst,
    input  logic take_i,
    input  logic take_hi_i,
    input  logic ret_i,
    output logic in_hi_o,
    output logic in_lo_o
);

    logic in_hi_q, in_lo_q;
    logic hi_pop, lo_pop;

    assign hi_pop = ret_i & in_hi_q;
    assign lo_pop = ret_i & ~in_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_hi_q <= 1'b0;
            in_lo_q <= 1'b0;
        end else begin
            in_hi_q <= (in_hi_q & ~hi_pop) | (take_i & take_hi_i);
            in_lo_q <= (in_lo_q & ~lo_pop) | (take_i & ~take_hi_i);
        end
    end

    assign in_hi_o = in_hi_q;
    assign in_lo_o = in_lo_q;

    // R8
    no_take_in_hi_chk: assert property (@(posedge clk) disable iff (rst)
        take_i |-> !in_hi_q)
        else $error("entry while high level in service");

    // R8
    no_lo_over_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (take_i && !take_hi_i) |-> !in_lo_q)
        else $error("low level pre-empted low level");

    // R9
    pop_hi_first_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !take_i && in_hi_q) |=> (!in_hi_o && (in_lo_o == $past(in_lo_q))))
        else $error("return popped wrong level");

endmodule

// File: rtl/irq_arbiter8.sv
module irq_arbiter8
    import irq8_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  ext_n_i,
    input  logic [3:0]  periph_i,
    input  logic        sfr_we_i,
    input  logic [7:0]  sfr_addr_i,
    input  logic [7:0]  sfr_wdata_i,
    output logic [7:0]  sfr_rdata_o,
    input  logic        bit_we_i,
    input  logic [7:0]  bit_addr_i,
    input  logic        bit_val_i,
    output logic        irq_o,
    output logic [15:0] irq_vec_o,
    input  logic        ack_i,
    input  logic        reti_i
);

    // stored control fields
    logic [5:0]      en_q, en_d;
    logic            glob_q, glob_d;
    logic [5:0]      pr_q, pr_d;
    logic [NEXT-1:0] mode_q, mode_d;
    logic [1:0]      xen_q, xen_d;
    logic [1:0]      xpr_q, xpr_d;

    logic [NEXT-1:0] flag, flag_we, flag_val, ack_clr;
    logic            wh_en, wh_pr, wh_ext, wh_xc;
    logic            bh_en, bh_pr, bh_ext, bh_xc;
    logic [2:0]      bidx;
    bitwr_t          t;

    logic [NSRC-1:0] req, en_all, prio_all, live;
    logic            in_hi, in_lo, take;
    pick_t           pk;

    assign wh_en  = sfr_we_i && (sfr_addr_i == ADDR_EN);
    assign wh_pr  = sfr_we_i && (sfr_addr_i == ADDR_PR);
    assign wh_ext = sfr_we_i && (sfr_addr_i == ADDR_EXT);
    assign wh_xc  = sfr_we_i && (sfr_addr_i == ADDR_XC);
    assign bh_en  = bit_we_i && (bit_addr_i[7:3] == ADDR_EN[7:3]);
    assign bh_pr  = bit_we_i && (bit_addr_i[7:3] == ADDR_PR[7:3]);
    assign bh_ext = bit_we_i && (bit_addr_i[7:3] == ADDR_EXT[7:3]);
    assign bh_xc  = bit_we_i && (bit_addr_i[7:3] == ADDR_XC[7:3]);
    assign bidx   = bit_addr_i[2:0];

    always_comb begin
        for (int i = 0; i < 6; i++) begin
            t = bit_wr(wh_en, bh_en, bidx, bit_val_i, sfr_wdata_i[i], 3'(i));
            en_d[i] = t.we ? t.val : en_q[i];
            t = bit_wr(wh_pr, bh_pr, bidx, bit_val_i, sfr_wdata_i[i], 3'(i));
            pr_d[i] = t.we ? t.val : pr_q[i];
        end
        t = bit_wr(wh_en, bh_en, bidx, bit_val_i, sfr_wdata_i[7], 3'd7);
        glob_d = t.we ? t.val : glob_q;

        // pins 0 and 1: mode at 2c, flag at 2c+1
        for (int c = 0; c < 2; c++) begin
            t = bit_wr(wh_ext, bh_ext, bidx, bit_val_i, sfr_wdata_i[2*c], 3'(2*c));
            mode_d[c] = t.we ? t.val : mode_q[c];
            t = bit_wr(wh_ext, bh_ext, bidx, bit_val_i, sfr_wdata_i[2*c+1], 3'(2*c+1));
            flag_we[c]  = t.we;
            flag_val[c] = t.val;
        end
        // pins 2 and 3: mode, flag, enable, priority from nibble base
        for (int c = 2; c < 4; c++) begin
            t = bit_wr(wh_xc, bh_xc, bidx, bit_val_i, sfr_wdata_i[4*(c-2)], 3'(4*(c-2)));
            mode_d[c] = t.we ? t.val : mode_q[c];
            t = bit_wr(wh_xc, bh_xc, bidx, bit_val_i, sfr_wdata_i[4*(c-2)+1], 3'(4*(c-2)+1));
            flag_we[c]  = t.we;
            flag_val[c] = t.val;
            t = bit_wr(wh_xc, bh_xc, bidx, bit_val_i, sfr_wdata_i[4*(c-2)+2], 3'(4*(c-2)+2));
            xen_d[c-2] = t.we ? t.val : xen_q[c-2];
            t = bit_wr(wh_xc, bh_xc, bidx, bit_val_i, sfr_wdata_i[4*(c-2)+3], 3'(4*(c-2)+3));
            xpr_d[c-2] = t.we ? t.val : xpr_q[c-2];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            glob_q <= 1'b0;
            pr_q   <= '0;
            mode_q <= '0;
            xen_q  <= '0;
            xpr_q  <= '0;
        end else begin
            en_q   <= en_d;
            glob_q <= glob_d;
            pr_q   <= pr_d;
            mode_q <= mode_d;
            xen_q  <= xen_d;
            xpr_q  <= xpr_d;
        end
    end

    generate
        for (genvar c = 0; c < NEXT; c++) begin : g_pin
            assign ack_clr[c] = take && (pk.idx == pin_src(c));
            irq8_ext_chan #(.SYNC_STAGES(SYNC_STAGES)) chan_i (
                .clk         (clk),
                .rst         (rst),
                .pin_n_i     (ext_n_i[c]),
                .edge_mode_i (mode_q[c]),
                .sw_we_i     (flag_we[c]),
                .sw_val_i    (flag_val[c]),
                .ack_clr_i   (ack_clr[c]),
                .flag_o      (flag[c])
            );
        end
    endgenerate

    assign req = {flag[3], flag[2], periph_i[3], periph_i[2],
                  periph_i[1], flag[1], periph_i[0], flag[0]};
    assign en_all   = {xen_q, en_q};
    assign prio_all = {xpr_q, pr_q};
    assign live     = req & en_all & {NSRC{glob_q}};

    irq8_pick pick_i (
        .req_i   (live),
        .prio_i  (prio_all),
        .in_hi_i (in_hi),
        .in_lo_i (in_lo),
        .pick_o  (pk)
    );

    assign take = ack_i & pk.valid;

    irq8_nest nest_i (
        .clk       (clk),
        .rst       (rst),
        .take_i    (take),
        .take_hi_i (pk.hi),
        .ret_i     (reti_i),
        .in_hi_o   (in_hi),
        .in_lo_o   (in_lo)
    );

    assign irq_o     = pk.valid;
    assign irq_vec_o = vec_of(pk.idx);

    always_comb begin
        case (sfr_addr_i)
            ADDR_EN:  sfr_rdata_o = {glob_q, 1'b0, en_q};
            ADDR_PR:  sfr_rdata_o = {2'b00, pr_q};
            ADDR_EXT: sfr_rdata_o = {4'b0000, flag[1], mode_q[1], flag[0], mode_q[0]};
            ADDR_XC:  sfr_rdata_o = {xpr_q[1], xen_q[1], flag[3], mode_q[3],
                                     xpr_q[0], xen_q[0], flag[2], mode_q[2]};
            default:  sfr_rdata_o = 8'h00;
        endcase
    end

    // R5
    glob_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> glob_q)
        else $error("request presented with global enable off");

    // R4
    vec_range_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((irq_vec_o[2:0] == 3'd3) && (irq_vec_o < 16'h0040)))
        else $error("vector outside table");

    // R8
    hi_blocks_all_chk: assert property (@(posedge clk) disable iff (rst)
        in_hi |-> !irq_o)
        else $error("request presented during high-level service");

endmodule

// File: tb/irq_arbiter8_tb.sv
module irq_arbiter8_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ext_n = 4'hF;
    logic [3:0]  periph = 4'h0;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic        bit_we = 1'b0;
    logic [7:0]  bit_addr = 8'h00;
    logic        bit_val = 1'b0;
    logic        irq;
    logic [15:0] vec;
    logic        ack = 1'b0;
    logic        reti = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_arbiter8 dut_i (
        .clk         (clk),
        .rst         (rst),
        .ext_n_i     (ext_n),
        .periph_i    (periph),
        .sfr_we_i    (sfr_we),
        .sfr_addr_i  (sfr_addr),
        .sfr_wdata_i (sfr_wdata),
        .sfr_rdata_o (sfr_rdata),
        .bit_we_i    (bit_we),
        .bit_addr_i  (bit_addr),
        .bit_val_i   (bit_val),
        .irq_o       (irq),
        .irq_vec_o   (vec),
        .ack_i       (ack),
        .reti_i      (reti)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_we = 1'b0;
    endtask

    task automatic bwr(input logic [7:0] a, input logic v);
        @(negedge clk);
        bit_we = 1'b1; bit_addr = a; bit_val = v;
        @(negedge clk);
        bit_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        sfr_addr = a;
        #1;
        chk(sfr_rdata == exp, req, 32'(sfr_rdata), 32'(exp));
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse_reti();
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0;
    endtask

    // expected presentation: valid flag and vector
    task automatic irq_chk(input logic exp_v, input logic [15:0] exp_vec, input string req);
        #1;
        chk(irq == exp_v, req, 32'(irq), 32'(exp_v));
        if (exp_v) chk(vec == exp_vec, req, 32'(vec), 32'(exp_vec));
    endtask

    function automatic int lowest(input logic [7:0] m);
        int r = -1;
        for (int i = 7; i >= 0; i--) if (m[i]) r = i;
        return r;
    endfunction

    // drive request pattern indexed by source number (pins in level mode)
    task automatic drive_req(input logic [7:0] p);
        ext_n  = ~{p[7], p[6], p[2], p[0]};
        periph = {p[5], p[4], p[3], p[1]};
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        wait_n(4);
        rst = 1'b0;

        // R1 reset state
        rd_chk(8'hA8, 8'h00, "R1 en reg");
        rd_chk(8'hB8, 8'h00, "R1 prio reg");
        rd_chk(8'h88, 8'h00, "R1 pin01 reg");
        rd_chk(8'hC0, 8'h00, "R1 pin23 reg");
        irq_chk(1'b0, 16'h0, "R1 no request");

        // R2 map and reserved bits
        wr(8'hA8, 8'hFF); rd_chk(8'hA8, 8'hBF, "R2 en reg");
        wr(8'hB8, 8'hFF); rd_chk(8'hB8, 8'h3F, "R2 prio reg");
        wr(8'h88, 8'h05); rd_chk(8'h88, 8'h05, "R2 pin01 modes");
        wr(8'hC0, 8'hDD); rd_chk(8'hC0, 8'hDD, "R2 pin23 fields");
        wr(8'hA8, 8'h00); wr(8'hB8, 8'h00); wr(8'h88, 8'h00); wr(8'hC0, 8'h00);

        // R3 single-bit writes
        bwr(8'hC2, 1'b1); rd_chk(8'hC0, 8'h04, "R3 set bit 2");
        bwr(8'hC7, 1'b1); rd_chk(8'hC0, 8'h84, "R3 set bit 7");
        bwr(8'hC2, 1'b0); rd_chk(8'hC0, 8'h80, "R3 clear bit 2");
        bwr(8'hAF, 1'b1); rd_chk(8'hA8, 8'h80, "R3 global bit");
        rd_chk(8'hC0, 8'h80, "R3 other reg untouched");
        wr(8'hC0, 8'h00); wr(8'hA8, 8'h00);

        // R5 global enable off blocks everything
        wr(8'hA8, 8'h3F); wr(8'hC0, 8'h44);
        drive_req(8'hFF); wait_n(4);
        irq_chk(1'b0, 16'h0, "R5 global off");

        // R5 R6 R4 enable sweep, all requests, one level
        for (int e = 0; e < 256; e++) begin
            logic [7:0] em;
            em = 8'(e);
            wr(8'hA8, {1'b1, 1'b0, em[5:0]});
            wr(8'hC0, {1'b0, em[7], 2'b00, 1'b0, em[6], 2'b00});
            #1;
            irq_chk(em != 0, 16'(8 * lowest(em) + 3), "R5 enable sweep");
        end

        // R6 R7 R13 request sweep under several priority masks
        wr(8'hA8, 8'hBF);
        for (int qi = 0; qi < 4; qi++) begin
            logic [7:0] q;
            case (qi)
                0: q = 8'h00;
                1: q = 8'hFF;
                2: q = 8'hA5;
                default: q = 8'h3C;
            endcase
            wr(8'hB8, {2'b00, q[5:0]});
            wr(8'hC0, {q[7], 1'b1, 2'b00, q[6], 1'b1, 2'b00});
            for (int p = 0; p < 256; p++) begin
                logic [7:0] pm;
                logic [7:0] hm;
                int w;
                pm = 8'(p);
                hm = pm & q;
                w = (hm != 0) ? lowest(hm) : lowest(pm);
                @(negedge clk);
                drive_req(pm);
                wait_n(4);
                irq_chk(pm != 0, 16'(8 * w + 3), "R7 R6 priority sweep");
            end
        end
        drive_req(8'h00); wait_n(4);

        // R13 peripheral line takes effect in the same cycle
        wr(8'hB8, 8'h00); wr(8'hC0, 8'h00);
        @(negedge clk); periph = 4'b0100;
        irq_chk(1'b1, 16'h0023, "R13 same-cycle peripheral");
        periph = 4'b0000;
        irq_chk(1'b0, 16'h0, "R13 peripheral drop");

        // R8 R9 nesting
        wr(8'hB8, 8'h09);
        @(negedge clk); periph = 4'b0100;
        irq_chk(1'b1, 16'h0023, "R8 serial low");
        pulse_ack();
        irq_chk(1'b0, 16'h0, "R8 low in service");
        periph = 4'b0101;
        irq_chk(1'b0, 16'h0, "R8 equal level no preempt");
        periph = 4'b0111;
        irq_chk(1'b1, 16'h001B, "R8 high preempts low");
        pulse_ack();
        ext_n = 4'b1110; wait_n(4);
        irq_chk(1'b0, 16'h0, "R8 high blocks high");
        pulse_reti();
        irq_chk(1'b1, 16'h0003, "R9 high popped first");
        ext_n = 4'hF; periph = 4'b0101; wait_n(4);
        irq_chk(1'b0, 16'h0, "R9 low still in service");
        pulse_reti();
        irq_chk(1'b1, 16'h000B, "R9 low popped");
        periph = 4'b0000;
        wr(8'hB8, 8'h00);

        // R10 edge mode
        wr(8'hA8, 8'h81); wr(8'h88, 8'h01);
        @(negedge clk); ext_n = 4'b1110;
        wait_n(2); ext_n = 4'hF;
        wait_n(3);
        rd_chk(8'h88, 8'h03, "R10 edge flag set");
        irq_chk(1'b1, 16'h0003, "R10 edge request");
        wait_n(3);
        rd_chk(8'h88, 8'h03, "R10 flag held after pin rise");
        pulse_ack();
        rd_chk(8'h88, 8'h01, "R10 ack clears flag");
        pulse_reti();
        irq_chk(1'b0, 16'h0, "R10 nothing pending");

        // R12 software write on the detect cycle
        @(negedge clk); ext_n = 4'b1110;
        @(negedge clk);
        @(negedge clk);
        sfr_we = 1'b1; sfr_addr = 8'h88; sfr_wdata = 8'h01;
        @(negedge clk);
        sfr_we = 1'b0; ext_n = 4'hF;
        wait_n(2);
        rd_chk(8'h88, 8'h01, "R12 write beats edge");
        irq_chk(1'b0, 16'h0, "R12 no request");
        wr(8'h88, 8'h03);
        rd_chk(8'h88, 8'h03, "R12 software set");
        irq_chk(1'b1, 16'h0003, "R12 software set request");
        wr(8'h88, 8'h01);
        irq_chk(1'b0, 16'h0, "R12 software clear");

        // R11 level mode
        wr(8'h88, 8'h00);
        wr(8'h88, 8'h02);
        rd_chk(8'h88, 8'h00, "R11 write ignored");
        @(negedge clk); ext_n = 4'b1110; wait_n(4);
        rd_chk(8'h88, 8'h02, "R11 flag follows low pin");
        irq_chk(1'b1, 16'h0003, "R11 level request");
        pulse_ack();
        rd_chk(8'h88, 8'h02, "R11 ack leaves flag");
        irq_chk(1'b0, 16'h0, "R11 in service");
        pulse_reti();
        irq_chk(1'b1, 16'h0003, "R11 re-presented");
        ext_n = 4'hF; wait_n(4);
        rd_chk(8'h88, 8'h00, "R11 flag follows high pin");
        irq_chk(1'b0, 16'h0, "R11 released");

        done = 1'b1;
        report();
        $finish;
    end

endmodule